// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds one priority value for each interrupt line of an interrupt controller. Each value sits in an 8-bit field. Four fields share one 32-bit word, and the lane number equals the interrupt number modulo four. The parameter `NUM_IRQS` sets how many interrupts exist. The parameter `PRIO_BITS` sets how many priority bits each field actually stores, from 4 to 8. The stored bits are the most significant bits of the field. The bits below them are always zero, so software can find the implemented width by writing all ones and reading the value back.

Software reaches the bank over a simple synchronous register port. Accesses are either a full 32-bit word or a single byte. A byte access touches exactly one interrupt's field. Any field whose interrupt number is `NUM_IRQS` or higher does not exist: it reads as zero, and writes to it are dropped. This holds for whole words past the end and for the unused lanes of a partly filled last word. This block only stores the priorities. Arbitration between interrupts is done elsewhere.

Top module: `prio_bank`

## Requirements
- R1: After synchronous reset every field reads zero, and `rd_valid` is low with `rd_data` equal to zero.
- R2: A read request (`req`=1, `wr`=0) sampled on a clock edge drives `rd_valid` high with the data during the following cycle. A write request, or no request, leaves `rd_valid` low.
- R3: Each field keeps only its upper `PRIO_BITS` bits, and the same mask applies to all four lanes. For example, writing 0xFFFFFFFF to a fully implemented word reads back as four copies of the mask; with the default 5 bits this is 0xF8F8F8F8.
- R4: Writing zero to a word reads back as zero.
- R5: A word write stores every lane of `wr_data` at once, with lane i taken from bits [8i+7:8i], subject to the mask. With 5 bits, 0xFF7FBF3F reads back as 0xF878B838. For word accesses `addr[1:0]` is ignored.
- R6: A byte read (`byte_sel`=1) returns the field of lane `addr[1:0]` in `rd_data[7:0]` and zero in `rd_data[31:8]`.
- R7: A byte write takes its value from `wr_data[7:0]` and changes only the lane selected by `addr[1:0]`. The other three lanes of the word keep their contents.
- R8: A field whose interrupt number (the byte address) is at or above `NUM_IRQS` reads zero and ignores writes. Such a write leaves every implemented field unchanged, including fields whose word index would alias after truncation.
- R9: In the last, partly implemented word, the implemented lanes are fully writable (subject to R3) and the unimplemented lanes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| byte_sel | input | 1 | 1 = byte access, 0 = 32-bit word access |
| addr | input | ADDR_W | Byte address, equal to the interrupt number of the field |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read request |

## Verification
The bound checker watches every cycle for four things:
- the read latency;
- that no unimplemented low bit is ever set in returned data;
- that byte reads leave the upper three bytes zero;
- that a read of an address past the last interrupt, or of an unused lane of the last word, returns zero.

Some behaviours can only be shown by the bench's write-then-read scenarios. These are:
- the stored pattern coming back exactly;
- a byte write leaving its three neighbours untouched;
- writes beyond the limit leaving implemented fields (including aliasing ones) unchanged.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Field mask with the top nbits set.
  function automatic logic [LANE_W-1:0] field_mask(input int nbits);
    logic [LANE_W-1:0] m;
    m = '0;
    for (int b = 0; b < LANE_W; b++) begin
      if (b >= LANE_W - nbits) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/prio_bank_dec.sv
module prio_bank_dec
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQS = 38,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_sel,
  output logic [IDX_W-1:0]  idx,
  output logic [LANES-1:0]  lane_impl,
  output logic [LANES-1:0]  lane_hit
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_IRQS);

  logic [LANES-1:0] lane_sel;

  assign idx = addr[IDX_W+1:2];

  always_comb begin
    lane_sel = '0;
    if (byte_sel) lane_sel[addr[1:0]] = 1'b1;
    else          lane_sel = '1;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ADDR_W:0] irq_num;
    assign irq_num      = {1'b0, addr[ADDR_W-1:2], 2'(i)};
    assign lane_impl[i] = irq_num < LIMIT;
    assign lane_hit[i]  = lane_impl[i] & lane_sel[i];
  end
endmodule

// File: rtl/prio_bank_lane.sv
module prio_bank_lane
  import prio_bank_pkg::*;
#(
  parameter int DEPTH     = 10,
  parameter int IDX_W     = 4,
  parameter int PRIO_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wbyte,
  output logic [LANE_W-1:0] rbyte
);
  localparam int PAD = LANE_W - PRIO_BITS;

  logic [PRIO_BITS-1:0] mem [DEPTH];
  logic                 in_bounds;

  assign in_bounds = 32'(idx) < DEPTH;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < DEPTH; d++) mem[d] <= '0;
    end else if (we && in_bounds) begin
      mem[idx] <= wbyte[LANE_W-1 -: PRIO_BITS];
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign rbyte = in_bounds ? {mem[idx], {PAD{1'b0}}} : '0;
    end else begin : g_full
      assign rbyte = in_bounds ? mem[idx] : '0;
    end
  endgenerate
endmodule

// File: rtl/prio_bank.sv
module prio_bank
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQS  = 38,
  parameter int PRIO_BITS = 5,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              wr,
  input  logic              byte_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = (NUM_IRQS + LANES - 1) / LANES;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  initial begin
    if (PRIO_BITS < 4 || PRIO_BITS > 8)
      $error("PRIO_BITS must lie in 4..8");
    if (NUM_IRQS < 1 || NUM_IRQS > (1 << ADDR_W))
      $error("NUM_IRQS must fit the address space");
    if (IDX_W + 2 > ADDR_W)
      $error("ADDR_W too small for NUM_IRQS");
  end

  logic [IDX_W-1:0]  idx;
  logic [LANES-1:0]  lane_impl, lane_hit;
  logic [LANE_W-1:0] rbyte [LANES];
  logic [WORD_W-1:0] rd_next;

  prio_bank_dec #(
    .NUM_IRQS(NUM_IRQS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .byte_sel(byte_sel), .idx(idx),
    .lane_impl(lane_impl), .lane_hit(lane_hit)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] wbyte;
    assign wbyte = byte_sel ? wr_data[LANE_W-1:0] : wr_data[i*LANE_W +: LANE_W];
    prio_bank_lane #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .PRIO_BITS(PRIO_BITS)
    ) u_lane (
      .clk(clk), .rst(rst), .we(req && wr && lane_hit[i]),
      .idx(idx), .wbyte(wbyte), .rbyte(rbyte[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (byte_sel) begin
      if (lane_hit[addr[1:0]]) rd_next[LANE_W-1:0] = rbyte[addr[1:0]];
    end else begin
      for (int i = 0; i < LANES; i++)
        if (lane_impl[i]) rd_next[i*LANE_W +: LANE_W] = rbyte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= req && !wr;
      if (req && !wr) rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQS  = 38,
  parameter int PRIO_BITS = 5,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              wr,
  input logic              byte_sel,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rd_data,
  input logic              rd_valid
);
  localparam logic [7:0] MASK = field_mask(PRIO_BITS);

  logic        beyond;
  logic [31:0] impl_bits;

  always_comb begin
    beyond = byte_sel ? (int'(addr) >= NUM_IRQS)
                      : (int'({addr[ADDR_W-1:2], 2'b00}) >= NUM_IRQS);
    for (int i = 0; i < 4; i++)
      impl_bits[i*8 +: 8] = (int'({addr[ADDR_W-1:2], 2'b00}) + i < NUM_IRQS) ? 8'hFF : 8'h00;
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && rd_data == 32'h0));

  // R2
  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(req && !wr)));

  // R3
  p_low_bits_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data & ~{4{MASK}}) == 32'h0));

  // R6
  p_byte_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(byte_sel)) |-> (rd_data[31:8] == 24'h0));

  // R8
  p_beyond_raz_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(beyond)) |-> (rd_data == 32'h0));

  // R9
  p_unused_lanes_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !$past(byte_sel)) |-> ((rd_data & ~$past(impl_bits)) == 32'h0));
endmodule

bind prio_bank prio_bank_chk #(
  .NUM_IRQS(NUM_IRQS), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .wr(wr), .byte_sel(byte_sel),
  .addr(addr), .rd_data(rd_data), .rd_valid(rd_valid)
);

// File: tb/tb_prio_bank.sv
module tb_prio_bank;
  localparam int NUM_IRQS  = 38;
  localparam int PRIO_BITS = 5;
  localparam int ADDR_W    = 8;
  localparam logic [7:0]  M  = 8'hFF << (8 - PRIO_BITS);
  localparam logic [31:0] M4 = {4{M}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, wr = 1'b0, byte_sel = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  prio_bank #(.NUM_IRQS(NUM_IRQS), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .byte_sel(byte_sel),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic b);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; byte_sel = b; addr = a; wr_data = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    check("R2 no rd_valid after write", {31'h0, rd_valid}, 32'h0);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, input logic b, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; byte_sel = b; addr = a;
    @(negedge clk);
    req = 1'b0;
    check("R2 rd_valid after read", {31'h0, rd_valid}, 32'h1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rd_valid low", {31'h0, rd_valid}, 32'h0);
    check("R1 rd_data zero", rd_data, 32'h0);
    for (int w = 0; w < 40; w += 4) begin
      bus_read(ADDR_W'(w), 1'b0, d);
      check("R1 field reset", d, 32'h0);
    end
  endtask

  task automatic t_discover();
    logic [31:0] d;
    bus_write(8'd0, 32'hFFFF_FFFF, 1'b0);
    bus_read(8'd0, 1'b0, d);
    check("R3 all-ones gives mask", d, M4);
    bus_write(8'd0, 32'h0, 1'b0);
    bus_read(8'd0, 1'b0, d);
    check("R4 zero reads zero", d, 32'h0);
  endtask

  task automatic t_pattern();
    logic [31:0] d;
    bus_write(8'd4, 32'hFF7F_BF3F, 1'b0);
    bus_read(8'd4, 1'b0, d);
    check("R5 pattern preserved", d, 32'hFF7F_BF3F & M4);
    bus_read(8'd6, 1'b0, d);
    check("R5 addr low bits ignored", d, 32'hFF7F_BF3F & M4);
  endtask

  task automatic t_bytes();
    logic [31:0] d;
    bus_read(8'd5, 1'b1, d);
    check("R6 byte read lane1", d, {24'h0, 8'hBF & M});
    bus_read(8'd7, 1'b1, d);
    check("R6 byte read lane3", d, {24'h0, 8'hFF & M});
    bus_write(8'd6, 32'hAAAA_AA1F, 1'b1);
    bus_read(8'd4, 1'b0, d);
    check("R7 byte write one lane", d, 32'hFF1F_BF3F & M4);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    bus_write(8'd36, 32'hFFFF_FFFF, 1'b0);
    bus_read(8'd36, 1'b0, d);
    check("R9 last word lanes", d, {16'h0, M, M});
    bus_read(8'd38, 1'b1, d);
    check("R9 unused lane byte", d, 32'h0);
    bus_read(8'd37, 1'b1, d);
    check("R9 used lane byte", d, {24'h0, M});
  endtask

  task automatic t_beyond();
    logic [31:0] d;
    bus_write(8'd0, 32'h1828_3848, 1'b0);
    bus_write(8'd32, 32'hA5A5_5A5A, 1'b0);
    bus_write(8'd40, 32'hFFFF_FFFF, 1'b0);
    bus_write(8'd64, 32'hFFFF_FFFF, 1'b0);
    bus_write(8'd96, 32'hFFFF_FFFF, 1'b0);
    bus_write(8'd252, 32'hFFFF_FFFF, 1'b0);
    bus_write(8'd38, 32'h0000_00FF, 1'b1);
    bus_read(8'd40, 1'b0, d);
    check("R8 beyond word reads zero", d, 32'h0);
    bus_read(8'd252, 1'b0, d);
    check("R8 top word reads zero", d, 32'h0);
    bus_read(8'd39, 1'b1, d);
    check("R8 beyond byte reads zero", d, 32'h0);
    bus_read(8'd0, 1'b0, d);
    check("R8 aliased word 0 intact", d, 32'h1828_3848 & M4);
    bus_read(8'd32, 1'b0, d);
    check("R8 word 8 intact", d, 32'hA5A5_5A5A & M4);
    bus_read(8'd36, 1'b0, d);
    check("R8 last word intact", d, {16'h0, M, M});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_discover();
    t_pattern();
    t_bytes();
    t_partial();
    t_beyond();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule